// File: doc/BRIEF.md
# Accumulator Processor Core with Timed Control Sequence

This block is a 16-bit processor with a single accumulator and a 12-bit word address space. It drives a synchronous memory port made of an address, a write word, a read word and separate read and write strobes. The memory address always comes from the internal address register. A three-bit step counter drives every instruction through a fixed series of timing states. Each instruction is fetched in T0 to T2, has an optional indirect address lookup in T3, and runs its execute steps from T4 to at most T6.

The core executes the seven memory-operand instructions itself: bitwise AND, add with carry out, load, store, unconditional jump, call with return-address linkage, and increment-and-skip-if-zero. Words with opcode 111 are not memory-operand instructions. For these the core raises one of two decoded strobes in T3 and presents the low twelve instruction bits, so that companion units can carry out register or I/O operations. The core recognises one such operation itself, the halt. The program counter, the accumulator, the carry flag and a sticky halt flag are brought out so that checkers can observe them.

Top module: `acc_cpu`

## Requirements
- R1: After reset PC, AC, the carry flag and the halt flag are zero. The first cycle is T0 with no memory strobe, and the next cycle reads address 0.
- R2: Fetch takes three cycles. In T0, AR is loaded from PC. In T1, the word at AR is read into IR and PC is incremented. In T2, AR is loaded from IR[11:0] and I is loaded from IR[15]. IR[14:12] is the opcode.
- R3: If the opcode is not 111 and IR[15] is 1, T3 reads the word at AR and loads its low 12 bits into AR as the operand address. If IR[15] is 0, T3 does nothing.
- R4: AND (opcode 000), ADD (001) and LDA (010) read the operand into DR in T4. In T5 they load AC with AC&DR, AC+DR or DR respectively. ADD puts its carry out in the carry flag. Each of these instructions takes 6 cycles.
- R5: STA (011) writes AC to the operand address in T4 and takes 5 cycles. The read strobe and the write strobe are never high in the same cycle.
- R6: BUN (100) loads PC from the operand address in T4 and takes 5 cycles.
- R7: BSA (101) writes the return address (PC after fetch) to the operand address X and ends with PC = X+1, taking 6 cycles.
- R8: ISZ (110) reads the operand in T4, increments it in T5, and writes it back in T6. If the incremented value is zero it also increments PC in T6. It takes 7 cycles.
- R9: For opcode 111, T3 raises the register-class strobe when IR[15]=0 or the I/O-class strobe when IR[15]=1, presents IR[11:0], and ends the instruction (4 cycles). At most one of the two strobes is high in any cycle.
- R10: An opcode-111 word with IR[15]=0 and IR[0]=1 sets the halt flag at the end of its T3. Once set, the flag stays set until reset. While it is set, there are no memory strobes and PC holds its value.
- R11: The step counter either advances by one or returns to T0 in each cycle. It never skips a state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory word address (AR) |
| mem_wdata_o | output | 16 | Memory write word |
| mem_rdata_i | input | 16 | Memory read word, valid in the cycle its address is presented |
| mem_rd_o | output | 1 | Read strobe; the data is taken at the closing clock edge |
| mem_wr_o | output | 1 | Write strobe; the memory writes at the closing clock edge |
| ext_rref_o | output | 1 | Register-class operation strobe (T3) |
| ext_io_o | output | 1 | I/O-class operation strobe (T3) |
| ext_bits_o | output | 12 | Low twelve instruction bits for the companion units |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| halt_o | output | 1 | Sticky halt flag |

## Verification
The assertions check in every cycle that the step counter only advances by one or returns to T0, and that each T1 reads from the address that PC held in T0. They also check that the read and write strobes never overlap, that at most one of the two operation strobes is high and that either one ends the instruction, and that the halt flag is sticky and silences the memory port. Only the bench scenarios can show the data results: the AND, add and load values including the carry, the indirect address lookup, the return word stored by a call, and the counted loop that exits through the skip. The scenarios also check each instruction's cycle count through the exact cycle in which halt rises.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned OPC_W = 3;

  typedef enum logic [1:0] {
    ALU_AND  = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_PASS = 2'd2
  } alu_op_e;
endpackage

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int unsigned N_TSTATE = 7,
  localparam int unsigned SC_W = $clog2(N_TSTATE)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                hold_i,
  output logic [SC_W-1:0]     sc_o,
  output logic [N_TSTATE-1:0] t_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sc_q <= '0;
    else if (hold_i) sc_q <= sc_q;
    else if (clr_i)  sc_q <= '0;
    else             sc_q <= sc_q + SC_W'(1);
  end

  for (genvar k = 0; k < N_TSTATE; k++) begin : g_tdec
    assign t_o[k] = (sc_q == SC_W'(k));
  end

  assign sc_o = sc_q;
endmodule

// File: rtl/acc_decode.sv
module acc_decode #(
  parameter int unsigned OPC_W = 3,
  localparam int unsigned ND = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic [ND-1:0]    d_o
);
  for (genvar k = 0; k < ND; k++) begin : g_ddec
    assign d_o[k] = (opc_i == OPC_W'(k));
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum   = {1'b0, a_i} + {1'b0, b_i};
    cy_o  = 1'b0;
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_ADD: begin
        res_o = sum[DATA_W-1:0];
        cy_o  = sum[DATA_W];
      end
      default: res_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned N_TSTATE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              ext_rref_o,
  output logic              ext_io_o,
  output logic [ADDR_W-1:0] ext_bits_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic              e_o,
  output logic              halt_o
);
  localparam int unsigned SC_W    = $clog2(N_TSTATE);
  localparam int unsigned ND      = 1 << OPC_W;
  localparam int unsigned IND_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - ADDR_W;

  logic [ADDR_W-1:0]   pc_q, ar_q;
  logic [DATA_W-1:0]   ir_q, dr_q, ac_q;
  logic                e_q, i_q, halt_q;
  logic [SC_W-1:0]     sc_q;
  logic [N_TSTATE-1:0] t_raw, t;
  logic [ND-1:0]       d;
  logic                sc_clr, mref, rd_opnd;
  alu_op_e             alu_op;
  logic [DATA_W-1:0]   alu_res;
  logic                alu_cy;

  acc_seq #(.N_TSTATE(N_TSTATE)) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sc_clr),
    .hold_i(halt_q),
    .sc_o  (sc_q),
    .t_o   (t_raw)
  );

  acc_decode #(.OPC_W(OPC_W)) u_dec (
    .opc_i(ir_q[IND_BIT-1 -: OPC_W]),
    .d_o  (d)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (alu_op),
    .a_i  (ac_q),
    .b_i  (dr_q),
    .res_o(alu_res),
    .cy_o (alu_cy)
  );

  // a halted core keeps T0 but performs nothing
  assign t       = t_raw & {N_TSTATE{~halt_q}};
  assign mref    = ~d[7];
  assign rd_opnd = d[0] | d[1] | d[2] | d[6];
  assign alu_op  = d[0] ? ALU_AND : (d[1] ? ALU_ADD : ALU_PASS);

  assign sc_clr = (t[3] & d[7])
                | (t[4] & (d[3] | d[4]))
                | (t[5] & (d[0] | d[1] | d[2] | d[5]))
                | (t[6] & d[6]);

  assign mem_addr_o  = ar_q;
  assign mem_rd_o    = t[1] | (t[3] & mref & i_q) | (t[4] & rd_opnd);
  assign mem_wr_o    = (t[4] & (d[3] | d[5])) | (t[6] & d[6]);
  assign mem_wdata_o = d[3] ? ac_q : (d[5] ? {{PAD_W{1'b0}}, pc_q} : dr_q);

  assign ext_rref_o = t[3] & d[7] & ~i_q;
  assign ext_io_o   = t[3] & d[7] & i_q;
  assign ext_bits_o = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ar_q   <= '0;
      ir_q   <= '0;
      dr_q   <= '0;
      ac_q   <= '0;
      e_q    <= 1'b0;
      i_q    <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (t[0]) ar_q <= pc_q;
      if (t[1]) begin
        ir_q <= mem_rdata_i;
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (t[2]) begin
        ar_q <= ir_q[ADDR_W-1:0];
        i_q  <= ir_q[IND_BIT];
      end
      if (t[3] & mref & i_q) ar_q <= mem_rdata_i[ADDR_W-1:0];
      if (t[3] & d[7] & ~i_q & ir_q[0]) halt_q <= 1'b1;
      if (t[4] & rd_opnd) dr_q <= mem_rdata_i;
      if (t[4] & d[4]) pc_q <= ar_q;
      if (t[4] & d[5]) ar_q <= ar_q + ADDR_W'(1);
      if (t[5] & (d[0] | d[1] | d[2])) begin
        ac_q <= alu_res;
        if (d[1]) e_q <= alu_cy;
      end
      if (t[5] & d[5]) pc_q <= ar_q;
      if (t[5] & d[6]) dr_q <= dr_q + DATA_W'(1);
      if (t[6] & d[6] & (dr_q == '0)) pc_q <= pc_q + ADDR_W'(1);
    end
  end

  assign pc_o   = pc_q;
  assign ac_o   = ac_q;
  assign e_o    = e_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SC_W-1:0]   sc_q,
  input logic              halt_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              ext_rref_o,
  input logic              ext_io_o
);
  a_r11_sc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |=> ((sc_q == '0) || (sc_q == SC_W'($past(sc_q) + 1'b1))));

  a_r2_fetch_from_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_q == SC_W'(1) && !halt_o) |-> (mem_rd_o && mem_addr_o == $past(pc_o)));

  a_r5_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r9_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_rref_o, ext_io_o}));

  a_r9_strobe_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rref_o || ext_io_o) |=> (sc_q == '0));

  a_r10_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r10_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!mem_rd_o && !mem_wr_o));

  a_r10_halt_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(pc_o));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sc_q      (sc_q),
  .halt_o    (halt_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .mem_addr_o(mem_addr_o),
  .pc_o      (pc_o),
  .ext_rref_o(ext_rref_o),
  .ext_io_o  (ext_io_o)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr, ext_bits, pc;
  logic [15:0] mem_wdata, mem_rdata, ac;
  logic        mem_rd, mem_wr, ext_rref, ext_io, e, halt;

  logic [15:0] mem [256];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  acc_cpu uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .ext_rref_o(ext_rref), .ext_io_o(ext_io), .ext_bits_o(ext_bits),
    .pc_o(pc), .ac_o(ac), .e_o(e), .halt_o(halt)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (ld_we)       mem[ld_a] <= ld_d;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    ld_a = a; ld_d = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic setup();
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
  endtask

  task automatic go();
    rst_ni = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    setup();
    chk("R1 pc in reset", pc, 0);
    chk("R1 ac in reset", ac, 0);
    chk("R1 halt in reset", {e, halt}, 0);
    poke(8'h00, 16'h7001);
    go();
    chk("R1 T0 no strobe", {mem_rd, mem_wr}, 0);
    step(1);
    chk("R1 first read at 0", {mem_rd, mem_addr}, {1'b1, 12'h000});
  endtask

  task automatic t_arith();
    int rd_seen = 0;
    setup();
    poke(8'h00, 16'h2020); poke(8'h01, 16'h1021);
    poke(8'h02, 16'h0022); poke(8'h03, 16'h7001);
    poke(8'h20, 16'h1234); poke(8'h21, 16'h0F0F); poke(8'h22, 16'hFF00);
    go();
    step(21);
    chk("R4 not halted before 22 cycles", halt, 0);
    step(1);
    chk("R10 halt after 6+6+6+4 cycles", halt, 1);
    chk("R4 and/add/lda result", ac, 16'h2100);
    chk("R2 pc past halt word", pc, 12'h004);
    chk("R4 no carry", e, 0);
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (mem_rd || mem_wr) rd_seen++;
    end
    chk("R10 quiet while halted", rd_seen, 0);
    chk("R10 pc frozen", pc, 12'h004);
  endtask

  task automatic t_carry();
    setup();
    poke(8'h00, 16'h2020); poke(8'h01, 16'h1021); poke(8'h02, 16'h7001);
    poke(8'h20, 16'hFFFF); poke(8'h21, 16'h0002);
    go();
    step(40);
    chk("R4 add wraps", ac, 16'h0001);
    chk("R4 add carry out", e, 1);
  endtask

  task automatic t_indirect();
    setup();
    poke(8'h00, 16'hA030); poke(8'h01, 16'hB031); poke(8'h02, 16'h7001);
    poke(8'h30, 16'h0040); poke(8'h40, 16'h5A5A); poke(8'h31, 16'h0050);
    go();
    step(40);
    chk("R3 indirect load", ac, 16'h5A5A);
    chk("R3 indirect store", mem[8'h50], 16'h5A5A);
    chk("R3 pointer untouched", mem[8'h31], 16'h0050);
  endtask

  task automatic t_store_jump();
    setup();
    poke(8'h00, 16'h2020); poke(8'h01, 16'h3021); poke(8'h02, 16'h4005);
    poke(8'h03, 16'h2022); poke(8'h04, 16'h7001); poke(8'h05, 16'h7001);
    poke(8'h20, 16'h00C3); poke(8'h22, 16'hFFFF);
    go();
    step(11);
    chk("R5 store written after 6+5 cycles", mem[8'h21], 16'h00C3);
    step(40);
    chk("R6 jump skipped 3 and 4", pc, 12'h006);
    chk("R6 skipped load had no effect", ac, 16'h00C3);
  endtask

  task automatic t_call();
    setup();
    poke(8'h00, 16'h5010); poke(8'h01, 16'h7001);
    poke(8'h11, 16'h2020); poke(8'h12, 16'hC010); poke(8'h20, 16'h0777);
    go();
    step(6);
    chk("R7 pc at X+1 after 6 cycles", pc, 12'h011);
    chk("R7 return word stored", mem[8'h10], 16'h0001);
    step(40);
    chk("R7 returned through indirect jump", pc, 12'h002);
    chk("R7 subroutine body ran", ac, 16'h0777);
  endtask

  task automatic t_isz();
    setup();
    poke(8'h00, 16'h6020); poke(8'h01, 16'h4000); poke(8'h02, 16'h7001);
    poke(8'h20, 16'hFFFD);
    go();
    step(34);
    chk("R8 loop not done at 34", halt, 0);
    step(1);
    chk("R8 loop exits at cycle 35", halt, 1);
    chk("R8 counter reached zero", mem[8'h20], 16'h0000);
    chk("R8 skip taken", pc, 12'h003);
    setup();
    poke(8'h00, 16'h6021); poke(8'h01, 16'h7001); poke(8'h02, 16'h2022);
    poke(8'h21, 16'h0005); poke(8'h22, 16'h1234);
    go();
    step(40);
    chk("R8 nonzero incremented", mem[8'h21], 16'h0006);
    chk("R8 no skip on nonzero", {pc, ac}, {12'h002, 16'h0000});
  endtask

  task automatic t_strobes();
    setup();
    poke(8'h00, 16'h7800); poke(8'h01, 16'hF080); poke(8'h02, 16'h7001);
    go();
    step(3);
    chk("R9 register strobe in T3", {ext_rref, ext_io, ext_bits}, {2'b10, 12'h800});
    step(1);
    chk("R9 strobe ends instruction", {ext_rref, ext_io, mem_rd}, 3'b000);
    step(3);
    chk("R9 io strobe in T3", {ext_rref, ext_io, ext_bits}, {2'b01, 12'h080});
    step(5);
    chk("R10 halt after 4+4+4 cycles", halt, 1);
    chk("R9 core state untouched", {pc, ac}, {12'h003, 16'h0000});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_arith();
    t_carry();
    t_indirect();
    t_store_jump();
    t_call();
    t_isz();
    t_strobes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule